// File: doc/BRIEF.md
# Four-Source Event Interrupt Aggregator

This block collects single-cycle event pulses from four DMA channels of a crypto feed unit and turns them into one level-sensitive interrupt request. Each event is captured in a sticky status bit that stays set until software acknowledges it. An enable mask selects which captured events may raise the interrupt. The mask has no direct write path. Software changes it only through two strobe addresses: one that turns bits on and one that turns bits off. This lets several software agents change their own sources without a read-modify-write race.

Software reads the status and the masked pending view over a simple 32-bit register bus. Reads are combinational on the address. Writes take effect on the next rising clock edge. To acknowledge, software writes back the pending value it read. An event that arrives in the same cycle as its own acknowledge is kept, so no event is lost.

Top module: `crypto_irq_agg`

## Requirements
- R1: After reset, the status register, the enable mask and the interrupt output are all zero.
- R2: A one-cycle pulse on an event input sets the matching status bit, which reads back at offset 0x00 whatever the mask is. The bit mapping is bit 3 block-receive DMA, bit 2 block-transmit DMA, bit 1 hash-receive DMA and bit 0 public-key DMA.
- R3: A write to offset 0x04 sets each mask bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to offset 0x08 clears each mask bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A read of offset 0x04 or of offset 0x08 returns the current enable mask.
- R6: A read of offset 0x0C returns the status bits AND the enable mask.
- R7: A write to offset 0x0C clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When an event pulse and a clearing write to offset 0x0C hit the same bit in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when at least one pending bit (status AND mask) is set.
- R10: A write to offset 0x00 changes neither status nor mask. A read of any unmapped address, for example 0x10, returns zero. Read bits above bit 3 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| evtIn | input | 4 | Event pulses, bit mapping as in R2 |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions assume that each event input is a synchronous pulse. They also assume that the bus holds at most one write per cycle, so that a set strobe and a clear strobe of the mask never coincide. The bench drives every event and every bus access on the falling edge, one access per cycle, and never overlaps two writes. It raises event pulses together with an acknowledge write only in the deliberate collision case of R8.

// File: rtl/crypto_irq_agg_pkg.sv
package crypto_irq_agg_pkg;

  localparam int OFS_STAT = 'h00;
  localparam int OFS_ESET = 'h04;
  localparam int OFS_ECLR = 'h08;
  localparam int OFS_PEND = 'h0C;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2,
    RD_PEND = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrSet;
    logic   wrClr;
    logic   wrAck;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/crypto_irq_agg_ctrl.sv
module crypto_irq_agg_ctrl
  import crypto_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strb
);

  logic hitStat, hitSet, hitClr, hitPend;

  assign hitStat = (busAddr == ADDR_W'(OFS_STAT));
  assign hitSet  = (busAddr == ADDR_W'(OFS_ESET));
  assign hitClr  = (busAddr == ADDR_W'(OFS_ECLR));
  assign hitPend = (busAddr == ADDR_W'(OFS_PEND));

  always_comb begin
    strb.wrSet = busWe && hitSet;
    strb.wrClr = busWe && hitClr;
    strb.wrAck = busWe && hitPend;
    if (hitStat)               strb.rdSel = RD_STAT;
    else if (hitSet || hitClr) strb.rdSel = RD_MASK;
    else if (hitPend)          strb.rdSel = RD_PEND;
    else                       strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/crypto_irq_agg_dp.sv
module crypto_irq_agg_dp
  import crypto_irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] pendVec;

  // Per-source sticky status: a new event overrides a clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic clrHit;
    assign clrHit = strb.wrAck && wrBits[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             statusQ[i] <= 1'b0;
      else if (evtIn[i])     statusQ[i] <= 1'b1;
      else if (clrHit)       statusQ[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        maskQ[i] <= 1'b0;
      else if (strb.wrSet && wrBits[i]) maskQ[i] <= 1'b1;
      else if (strb.wrClr && wrBits[i]) maskQ[i] <= 1'b0;
    end
  end

  assign pendVec = statusQ & maskQ;
  assign irqOut  = |pendVec;

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_STAT: rdData[NUM_SRC-1:0] = statusQ;
      RD_MASK: rdData[NUM_SRC-1:0] = maskQ;
      RD_PEND: rdData[NUM_SRC-1:0] = pendVec;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/crypto_irq_agg.sv
module crypto_irq_agg
  import crypto_irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               irqOut
);

  ctrlStrobe_t        strb;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  crypto_irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  crypto_irq_agg_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (busWdata[NUM_SRC-1:0]),
    .evtIn   (evtIn),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .rdData  (busRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/crypto_irq_agg_chk.sv
module crypto_irq_agg_chk #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] evtIn,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irqOut
);

  logic wrSetC, wrClrC;
  logic [NUM_SRC-1:0] wb;
  assign wrSetC = busWe && (busAddr == ADDR_W'('h04));
  assign wrClrC = busWe && (busAddr == ADDR_W'('h08));
  assign wb     = busWdata[NUM_SRC-1:0];

  // R2 R8
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_evt
    event_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> statusQ[i]);
  end

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSetC |=> (((maskQ & $past(wb)) == $past(wb)) &&
                ((maskQ & ~$past(wb)) == ($past(maskQ) & ~$past(wb)))));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrClrC |=> (((maskQ & $past(wb)) == '0) &&
                ((maskQ & ~$past(wb)) == ($past(maskQ) & ~$past(wb)))));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSetC || wrClrC) |=> $stable(maskQ));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((statusQ & maskQ) != '0));

endmodule

bind crypto_irq_agg crypto_irq_agg_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .evtIn    (evtIn),
  .statusQ  (statusQ),
  .maskQ    (maskQ),
  .irqOut   (irqOut)
);

// File: tb/crypto_irq_agg_tb.sv
`timescale 1ns/1ps
module crypto_irq_agg_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  evtIn = '0;
  logic        irqOut;

  typedef struct {
    bit          isIrq;
    logic [31:0] expv;
    string       req;
  } sbItem_t;

  sbItem_t sbQ[$];
  bit      rdValid = 1'b0;
  int      total = 0;
  int      bad = 0;
  bit      doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  crypto_irq_agg u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .irqOut(irqOut)
  );

  // Monitor: pops expected items and compares 1 ns after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rdValid && sbQ.size() > 0) begin
        sbItem_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        act = it.isIrq ? {31'd0, irqOut} : busRdata;
        total++;
        if (act !== it.expv) begin
          bad++;
          $display("FAIL %s: actual=%0h expected=%0h", it.req, act, it.expv);
        end
      end
    end
  end

  task automatic chkRd(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    sbQ.push_back('{1'b0, e, r});
    rdValid = 1'b1;
    #2 rdValid = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string r);
    @(negedge clk);
    busWe = 1'b0;
    sbQ.push_back('{1'b1, {31'd0, e}, r});
    rdValid = 1'b1;
    #2 rdValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; evtIn = ev;
    @(negedge clk);
    busWe = 1'b0; evtIn = '0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    evtIn = ev;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkRd(8'h00, 32'h0, "R1 status");
    chkRd(8'h04, 32'h0, "R1 mask");
    chkIrq(1'b0, "R1 irq");
    // R2 capture with mask off: hash-receive is bit 1
    pulse(4'b0010);
    chkRd(8'h00, 32'h2, "R2 status");
    chkRd(8'h0C, 32'h0, "R6 pending masked");
    chkIrq(1'b0, "R9 irq masked");
    // R3 set
    wr(8'h04, 32'hFFFF_FFFA & 32'h0A, '0);
    chkRd(8'h04, 32'hA, "R3 set");
    wr(8'h04, 32'h1, '0);
    chkRd(8'h04, 32'hB, "R3 zero bits kept");
    chkRd(8'h08, 32'hB, "R5 mask at clear addr");
    // R4 clear
    wr(8'h08, 32'h8, '0);
    chkRd(8'h04, 32'h3, "R4 clear");
    chkRd(8'h0C, 32'h2, "R6 pending");
    chkIrq(1'b1, "R9 irq on");
    // more events: block-receive bit3 and public-key bit0
    pulse(4'b1001);
    chkRd(8'h00, 32'hB, "R2 status multi");
    chkRd(8'h0C, 32'h3, "R6 pending multi");
    // R7 acknowledge
    wr(8'h0C, 32'h2, '0);
    chkRd(8'h00, 32'h9, "R7 ack one bit");
    chkIrq(1'b1, "R9 irq still on");
    wr(8'h0C, 32'h1, '0);
    chkRd(8'h00, 32'h8, "R7 ack second");
    chkIrq(1'b0, "R9 irq off");
    // R8 collisions
    wr(8'h0C, 32'h8, 4'b1000);
    chkRd(8'h00, 32'h8, "R8 event wins");
    wr(8'h0C, 32'hF, 4'b0001);
    chkRd(8'h00, 32'h1, "R8 event wins others cleared");
    chkIrq(1'b1, "R9 irq after collision");
    // R10 ignored writes and unmapped reads
    wr(8'h00, 32'hFFFF_FFFF, '0);
    chkRd(8'h00, 32'h1, "R10 status untouched");
    chkRd(8'h04, 32'h3, "R10 mask untouched");
    chkRd(8'h10, 32'h0, "R10 unmapped read");
    wr(8'h04, 32'hFFFF_FFF0, '0);
    chkRd(8'h04, 32'h3, "R10 upper data bits ignored");
    repeat (2) @(negedge clk);
    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule